// File: doc/BRIEF.md
# Quadword Ring Buffer Writer

This block takes a burst of 128-bit quadwords arriving on a valid/ready stream and stores them into a circular buffer kept in local memory. Two configuration values set up the ring: a byte base address and a byte mask. The mask gives both the ring length, which is (mask >> 4) + 1 quadwords, and the slot where a burst begins, which is the incoming byte address ANDed with the mask and shifted right by four. Each quadword that follows goes to the next slot. After the last slot the next write lands on slot 0. Every write goes out on a simple RAM port at byte address base + slot × 16.

When a burst starts, the block checks it and stores the result in three flags. The burst is rejected without writing anything if the base lies outside the valid memory window or if the base or the target address has a nonzero low nibble. If the burst is longer than the ring, it is flagged as oversize and still carried out, so later quadwords overwrite earlier ones. The block ends every burst with a one-cycle done pulse and a success bit.

A separate drain-empty event sets a sticky interrupt status bit. It also sends a one-cycle clear strobe to the fill count of whichever of two consumers the drain-select field names.

Top module: `qring_writer`

## Requirements
- R1: After reset, busy, done, in_ready, mem_we, irq_empty and fill_clr are all 0.
- R2: The first quadword of an accepted burst is written at mem_addr = base + (((addr & mask) >> 4) × 16).
- R3: Each following quadword goes to the next slot. After slot mask >> 4 it goes back to slot 0.
- R4: mem_we is high only in a cycle where in_valid and in_ready are both high, and then mem_wdata equals in_data. A cycle where in_valid is low writes nothing and does not advance the slot.
- R5: done is high for exactly one cycle, the cycle after the edge that accepts the last quadword, and busy drops in the cycle after that. done_ok is 1 when the burst was accepted.
- R6: oversize is 1 when qwc > (mask >> 4) + 1, and every quadword of the burst is still written. When qwc equals the ring length, oversize is 0.
- R7: A base at or above MEM_LIMIT (default 0x0200_0000) raises base_err. The burst is rejected: no write occurs even when in_valid is high, and done rises in the cycle after start with done_ok = 0.
- R8: A base or target address whose bits [3:0] are not zero raises align_err, and the burst is rejected in the same way as in R7.
- R9: A burst with qwc = 0 writes nothing, and done rises in the cycle after start with done_ok = 1.
- R10: An empty_evt sets irq_empty on the next edge, and irq_empty stays at 1 until irq_clr is applied. If empty_evt and irq_clr arrive in the same cycle, irq_empty stays 1.
- R11: In the cycle after an empty_evt, fill_clr is 2'b01 if drain_sel is 2 and 2'b10 if drain_sel is 3. For drain_sel 0 or 1 it stays 2'b00. At all other times fill_clr is 2'b00.
- R12: A start that arrives while busy is ignored, and in_ready is 0 whenever the block is idle.
- R13: Base and mask are captured at start. Changing them during a burst has no effect on the addresses of that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_base | input | AW | Ring base byte address |
| cfg_mask | input | AW | Ring byte mask |
| start | input | 1 | Begin a burst (taken only when idle) |
| start_addr | input | AW | Target byte address |
| start_qwc | input | CW | Quadword count of the burst |
| in_valid | input | 1 | Quadword available |
| in_data | input | DW | Quadword payload |
| in_ready | output | 1 | Block accepts a quadword |
| busy | output | 1 | Burst in progress |
| mem_we | output | 1 | RAM write strobe |
| mem_addr | output | AW | RAM byte address |
| mem_wdata | output | DW | RAM write data |
| done | output | 1 | One-cycle end-of-burst pulse |
| done_ok | output | 1 | Burst accepted (valid with done) |
| oversize | output | 1 | Last burst was longer than the ring |
| base_err | output | 1 | Last burst had an invalid base |
| align_err | output | 1 | Last burst had a misaligned base or address |
| empty_evt | input | 1 | Drain-empty event |
| irq_clr | input | 1 | Clear the empty interrupt status |
| drain_sel | input | 2 | Consumer select: 2 or 3 picks a consumer, 0 or 1 picks none |
| irq_empty | output | 1 | Sticky drain-empty status |
| fill_clr | output | 2 | Fill-count clear strobe per consumer |

## Verification
A table of bursts tries several ring shapes. A start slot in the middle of a long ring shows that the masked start is used and not slot 0. A start near the end of a four-slot ring exposes the wrap. A burst whose count equals the ring length and one that is longer separate the oversize threshold on either side, and a single-slot ring shows the slot sitting at zero. An out-of-window base, a misaligned base and a misaligned address show the reject path, and a zero count shows an accepted burst with no writes. Directed cases add a stream bubble, a restart and configuration change in the middle of a burst, and every drain-select code.

// File: rtl/qrw_pkg.sv
package qrw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } qrw_state_e;

    localparam logic [1:0] DRAIN_C0 = 2'd2;
    localparam logic [1:0] DRAIN_C1 = 2'd3;
endpackage

// File: rtl/qrw_check.sv
module qrw_check #(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter logic [AW-1:0] MEM_LIMIT = 32'h0200_0000
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] mask,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] qwc,
    output logic          aerr,
    output logic          berr,
    output logic          ovs,
    output logic [AW-5:0] first_slot,
    output logic [AW-5:0] last_slot
);
    localparam int RW = AW - 3;
    localparam int EW = (CW > RW) ? CW : RW;

    logic [RW-1:0] ring_len;

    always_comb begin
        ring_len   = {1'b0, mask[AW-1:4]} + RW'(1);
        aerr       = (base[3:0] != 4'h0) || (addr[3:0] != 4'h0);
        berr       = (base >= MEM_LIMIT);
        ovs        = EW'(qwc) > EW'(ring_len);
        first_slot = addr[AW-1:4] & mask[AW-1:4];
        last_slot  = mask[AW-1:4];
    end
endmodule

// File: rtl/qrw_slot_step.sv
module qrw_slot_step #(
    parameter int SW = 28
) (
    input  logic [SW-1:0] slot,
    input  logic [SW-1:0] last,
    output logic [SW-1:0] nxt
);
    always_comb begin
        if (slot == last) begin
            nxt = '0;
        end else begin
            nxt = slot + SW'(1);
        end
    end
endmodule

// File: rtl/qrw_empty.sv
module qrw_empty
    import qrw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt,
    input  logic       clr,
    input  logic [1:0] sel,
    output logic       stat,
    output logic [1:0] fill_clr
);
    typedef struct packed {
        logic       stat;
        logic [1:0] fill;
    } emp_t;

    emp_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.fill = 2'b00;
        if (clr) begin
            r_d.stat = 1'b0;
        end
        if (evt) begin
            r_d.stat = 1'b1;
            if (sel == DRAIN_C0) begin
                r_d.fill = 2'b01;
            end else if (sel == DRAIN_C1) begin
                r_d.fill = 2'b10;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign stat     = r_q.stat;
    assign fill_clr = r_q.fill;
endmodule

// File: rtl/qring_writer.sv
module qring_writer
    import qrw_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 128,
    parameter int CW = 16,
    parameter logic [AW-1:0] MEM_LIMIT = 32'h0200_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_mask,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [CW-1:0] start_qwc,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          busy,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          done,
    output logic          done_ok,
    output logic          oversize,
    output logic          base_err,
    output logic          align_err,
    input  logic          empty_evt,
    input  logic          irq_clr,
    input  logic [1:0]    drain_sel,
    output logic          irq_empty,
    output logic [1:0]    fill_clr
);
    localparam int SW = AW - 4;

    typedef struct packed {
        qrw_state_e    st;
        logic [AW-1:0] base;
        logic [SW-1:0] slot;
        logic [SW-1:0] last;
        logic [CW-1:0] left;
        logic          ovs;
        logic          berr;
        logic          aerr;
        logic          ok;
    } wr_t;

    wr_t r_q, r_d;

    logic          chk_aerr, chk_berr, chk_ovs;
    logic [SW-1:0] chk_first, chk_last, slot_nxt;
    logic          take_q;

    qrw_check #(.AW(AW), .CW(CW), .MEM_LIMIT(MEM_LIMIT)) u_check (
        .base       (cfg_base),
        .mask       (cfg_mask),
        .addr       (start_addr),
        .qwc        (start_qwc),
        .aerr       (chk_aerr),
        .berr       (chk_berr),
        .ovs        (chk_ovs),
        .first_slot (chk_first),
        .last_slot  (chk_last)
    );

    qrw_slot_step #(.SW(SW)) u_step (
        .slot (r_q.slot),
        .last (r_q.last),
        .nxt  (slot_nxt)
    );

    qrw_empty u_empty (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (empty_evt),
        .clr      (irq_clr),
        .sel      (drain_sel),
        .stat     (irq_empty),
        .fill_clr (fill_clr)
    );

    assign in_ready = (r_q.st == ST_RUN);
    assign take_q   = in_ready && in_valid;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.base = cfg_base;
                    r_d.slot = chk_first;
                    r_d.last = chk_last;
                    r_d.left = start_qwc;
                    r_d.ovs  = chk_ovs;
                    r_d.berr = chk_berr;
                    r_d.aerr = chk_aerr;
                    r_d.ok   = !(chk_berr || chk_aerr);
                    if (chk_berr || chk_aerr || (start_qwc == '0)) begin
                        r_d.st = ST_FIN;
                    end else begin
                        r_d.st = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (take_q) begin
                    r_d.slot = slot_nxt;
                    r_d.left = r_q.left - CW'(1);
                    if (r_q.left == CW'(1)) begin
                        r_d.st = ST_FIN;
                    end
                end
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign mem_we    = take_q;
    assign mem_addr  = r_q.base + {r_q.slot, 4'h0};
    assign mem_wdata = in_data;
    assign done      = (r_q.st == ST_FIN);
    assign done_ok   = r_q.ok;
    assign oversize  = r_q.ovs;
    assign base_err  = r_q.berr;
    assign align_err = r_q.aerr;
endmodule

// File: rtl/qring_writer_chk.sv
module qring_writer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       busy,
    input logic       mem_we,
    input logic       done,
    input logic       base_err,
    input logic       align_err,
    input logic       empty_evt,
    input logic [1:0] fill_clr,
    input logic       irq_empty
);
    a_r4_we_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (in_valid && busy));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r7_reject_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (base_err || align_err)) |-> !mem_we);

    a_r10_irq_sets: assert property (@(posedge clk) disable iff (!rst_n)
        empty_evt |=> irq_empty);

    a_r11_fill_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_clr));

    a_r12_ready_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);
endmodule

bind qring_writer qring_writer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .busy      (busy),
    .mem_we    (mem_we),
    .done      (done),
    .base_err  (base_err),
    .align_err (align_err),
    .empty_evt (empty_evt),
    .fill_clr  (fill_clr),
    .irq_empty (irq_empty)
);

// File: tb/qring_writer_bench.sv
module qring_writer_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] mask;
        logic [31:0] addr;
        logic [15:0] qwc;
        logic        ok;
        logic        ovs;
        logic        berr;
        logic        aerr;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 32'h0000_00FF, 32'h0000_0030, 16'd4, 1'b1, 1'b0, 1'b0, 1'b0},
        '{32'h0000_2000, 32'h0000_003F, 32'h1234_0020, 16'd4, 1'b1, 1'b0, 1'b0, 1'b0},
        '{32'h0000_4000, 32'h0000_001F, 32'h0000_0010, 16'd5, 1'b1, 1'b1, 1'b0, 1'b0},
        '{32'h0300_0000, 32'h0000_00FF, 32'h0000_0000, 16'd3, 1'b0, 1'b0, 1'b1, 1'b0},
        '{32'h0000_1008, 32'h0000_00FF, 32'h0000_0000, 16'd2, 1'b0, 1'b0, 1'b0, 1'b1},
        '{32'h0000_1000, 32'h0000_00FF, 32'h0000_0014, 16'd2, 1'b0, 1'b0, 1'b0, 1'b1},
        '{32'h0000_1000, 32'h0000_00FF, 32'h0000_0040, 16'd0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{32'h0000_8000, 32'h0000_000F, 32'h0000_0050, 16'd3, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  cfg_base = '0, cfg_mask = '0, start_addr = '0;
    logic         start = 1'b0;
    logic [15:0]  start_qwc = '0;
    logic         in_valid = 1'b0;
    logic [127:0] in_data = '0;
    logic         in_ready, busy, mem_we, done, done_ok, oversize, base_err, align_err;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         empty_evt = 1'b0, irq_clr = 1'b0;
    logic [1:0]   drain_sel = 2'd0;
    logic         irq_empty;
    logic [1:0]   fill_clr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    qring_writer u_qring_writer (
        .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_mask(cfg_mask),
        .start(start), .start_addr(start_addr), .start_qwc(start_qwc),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .busy(busy),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done(done), .done_ok(done_ok), .oversize(oversize), .base_err(base_err),
        .align_err(align_err), .empty_evt(empty_evt), .irq_clr(irq_clr),
        .drain_sel(drain_sel), .irq_empty(irq_empty), .fill_clr(fill_clr)
    );

    task automatic chk(input logic cond, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // gap_at: index before which one idle stream cycle is inserted (-1: none)
    // disturb: restart and reconfigure while busy (needs qwc >= 3)
    task automatic run_burst(input vec_t v, input int gap_at, input bit disturb);
        int ring  = int'(v.mask >> 4) + 1;
        int first = int'((v.addr & v.mask) >> 4);
        bit gapped = 1'b0;
        logic [31:0] ea;
        @(negedge clk);
        cfg_base = v.base; cfg_mask = v.mask;
        start = 1'b1; start_addr = v.addr; start_qwc = v.qwc;
        @(negedge clk);
        start = 1'b0;
        if (v.ok) begin
            for (int i = 0; i < int'(v.qwc);) begin
                if (i == gap_at && !gapped) begin
                    in_valid = 1'b0;
                    #1 chk(!mem_we, "R4 idle stream cycle wrote", 128'(mem_we), 128'(0));
                    gapped = 1'b1;
                    @(negedge clk);
                    continue;
                end
                if (disturb && i == 1) begin
                    cfg_base = 32'h0001_0000; cfg_mask = 32'h0000_0FFF;
                    start = 1'b1; start_addr = 32'h0000_0070; start_qwc = 16'd9;
                end
                if (disturb && i == 2) start = 1'b0;
                in_valid = 1'b1;
                in_data  = {4{32'(i) ^ v.base}};
                ea = v.base + 32'(((first + i) % ring) * 16);
                #1;
                chk(mem_we, "R4 write strobe", 128'(mem_we), 128'(1));
                if (i == 0) chk(mem_addr == ea, "R2 first slot address", 128'(mem_addr), 128'(ea));
                else if (disturb) chk(mem_addr == ea, "R13 address with config changed", 128'(mem_addr), 128'(ea));
                else chk(mem_addr == ea, "R3 next slot address", 128'(mem_addr), 128'(ea));
                chk(mem_wdata == in_data, "R4 write data", mem_wdata, in_data);
                i++;
                @(negedge clk);
            end
            in_valid = 1'b0;
            #1;
            if (v.qwc == 16'd0) chk(done && done_ok && !mem_we, "R9 empty burst done", 128'({done, done_ok}), 128'(3));
            chk(done === 1'b1, "R5 done after last write", 128'(done), 128'(1));
            chk(done_ok === 1'b1, "R5 done_ok", 128'(done_ok), 128'(1));
            chk(oversize === v.ovs, "R6 oversize flag", 128'(oversize), 128'(v.ovs));
        end else begin
            in_valid = 1'b1;
            #1;
            chk(!mem_we && !in_ready, "R7/R8 rejected burst wrote", 128'(mem_we), 128'(0));
            chk(done && !done_ok, "R7/R8 reject done with fail", 128'({done, done_ok}), 128'(2));
            chk(base_err === v.berr, "R7 base_err", 128'(base_err), 128'(v.berr));
            chk(align_err === v.aerr, "R8 align_err", 128'(align_err), 128'(v.aerr));
            in_valid = 1'b0;
        end
        @(negedge clk);
        #1 chk(!done && !busy, "R5 single done then idle (R12 restart ignored)", 128'({done, busy}), 128'(0));
    endtask

    task automatic empty_case(input logic ev, input logic cl, input logic [1:0] sel,
                              input logic exp_irq, input logic [1:0] exp_fill);
        @(negedge clk);
        empty_evt = ev; irq_clr = cl; drain_sel = sel;
        @(negedge clk);
        empty_evt = 1'b0; irq_clr = 1'b0;
        #1;
        chk(irq_empty === exp_irq, "R10 irq_empty", 128'(irq_empty), 128'(exp_irq));
        chk(fill_clr === exp_fill, "R11 fill_clr", 128'(fill_clr), 128'(exp_fill));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 chk({busy, done, in_ready, mem_we, irq_empty, fill_clr} == '0, "R1 reset state",
               128'({busy, done, in_ready, mem_we, irq_empty, fill_clr}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        in_valid = 1'b1;
        #1 chk(!in_ready && !mem_we, "R12 idle not ready", 128'(in_ready), 128'(0));
        in_valid = 1'b0;

        for (int k = 0; k < NV; k++) run_burst(VECS[k], -1, 1'b0);

        run_burst(VECS[1], 2, 1'b0);
        run_burst(VECS[0], -1, 1'b1);

        empty_case(1'b1, 1'b0, 2'd2, 1'b1, 2'b01);
        empty_case(1'b0, 1'b0, 2'd2, 1'b1, 2'b00);
        empty_case(1'b1, 1'b0, 2'd3, 1'b1, 2'b10);
        empty_case(1'b1, 1'b0, 2'd0, 1'b1, 2'b00);
        empty_case(1'b0, 1'b1, 2'd1, 1'b0, 2'b00);
        empty_case(1'b1, 1'b0, 2'd1, 1'b1, 2'b00);
        empty_case(1'b1, 1'b1, 2'd2, 1'b1, 2'b01);
        empty_case(1'b0, 1'b1, 2'd0, 1'b0, 2'b00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule